// File: doc/BRIEF.md
# Debug Instruction Stream Parser

This block sits behind a serial frame receiver on a two-wire debug link. It watches the stream of received bytes and break conditions, in both directions of the half-duplex line, and works out how each instruction is laid out. The first byte after reset, after a break or after a finished instruction is an opcode. The parser decodes it and works out how many operand and data items follow, how wide each one is, and whether the host or the device sends it.

It gathers the bytes of each item in little-endian order and emits the item as one zero-extended word with a direction tag. It also reports every opcode with its width fields, and it pulses a completion strobe when an instruction's last byte arrives. A repeat prefix sets a count that multiplies the data phase of the next indirect load or store. A break abandons whatever is in progress and clears that count. Higher layers use the tagged items to rebuild memory and register traffic. Memory maps, register contents and key values are not decoded.

Top module: `dbg_insn_parser`

## Requirements
- R1: An opcode byte `b` gives the opcode `b[7:5]`: 0 direct load, 1 indirect load, 2 direct store, 3 indirect store, 4 control load, 5 repeat, 6 control store, 7 key. One cycle after its strobe, `op_valid` pulses with `op_code=b[7:5]`, `op_aw=b[3:2]+1` and `op_dw=b[1:0]+1`. An opcode byte never produces an item.
- R2: A direct load produces one host item of `op_aw` bytes and then one device item of `op_dw` bytes. A direct store produces one host item of `op_aw` bytes and then one host item of `op_dw` bytes.
- R3: Without a pending repeat count, an indirect load produces one device item of `op_dw` bytes and an indirect store produces one host item of `op_dw` bytes.
- R4: A control load produces one 1-byte device item. A control store produces one 1-byte host item. A key instruction produces eight 1-byte host items.
- R5: An item's bytes arrive least significant first. `item_data` holds them zero-extended to 32 bits, `item_width` gives the byte count (1 to 4), and `item_host` is 1 for host-written and 0 for device-returned items.
- R6: A repeat instruction carries one host item of `op_dw` bytes, with value N. The next indirect load or store then produces N+1 data items and resets the count to zero.
- R7: Instructions other than indirect load and store leave a pending repeat count untouched.
- R8: A break (`brk_valid`, which wins over a byte in the same cycle) produces no output. It abandons the current instruction, clears the repeat count and makes the next byte an opcode.
- R9: `cmd_done` pulses, with `cmd_code` set to the opcode, in the same cycle as the `item_valid` of an instruction's last item.
- R10: All outputs are registered and pulse exactly one cycle after the input strobe that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A valid frame byte is present |
| byte_data | input | 8 | Received byte value |
| brk_valid | input | 1 | Break condition seen on the line |
| op_valid | output | 1 | Opcode decoded (one-cycle pulse) |
| op_code | output | 3 | Decoded opcode |
| op_aw | output | 3 | Address width field plus one |
| op_dw | output | 3 | Data width field plus one |
| item_valid | output | 1 | Completed item (one-cycle pulse) |
| item_data | output | 32 | Item value, zero-extended |
| item_host | output | 1 | 1 host-written, 0 device-returned |
| item_width | output | 3 | Item width in bytes |
| cmd_done | output | 1 | Instruction complete (one-cycle pulse) |
| cmd_code | output | 3 | Opcode of the completed instruction |

## Verification
Some rules are checked by the assertions on every cycle. A break cycle is followed by no output at all, and it leaves the count at zero with the parser waiting for an opcode. Opcode reports and item reports never coincide. Completion always comes with an item. Every item's value fits inside its stated width. Only the bench's scenarios can show the right item count, widths and directions for each opcode, the byte order, and the repeat count passing across an unrelated instruction until an indirect access uses it up.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    OP_LDD = 3'd0, OP_LDI = 3'd1, OP_STD = 3'd2, OP_STI = 3'd3,
    OP_LCR = 3'd4, OP_RPT = 3'd5, OP_SCR = 3'd6, OP_KEY = 3'd7
  } op_e;

  // Layout of one instruction: optional host address phase, then a body phase.
  typedef struct packed {
    logic       a_en;    // one host address item first
    logic [2:0] a_w;     // its width in bytes
    logic [2:0] b_w;     // body item width in bytes
    logic       b_host;  // body direction
    logic       b_mult;  // body item count taken from repeat count + 1
    logic [3:0] b_fix;   // body item count when not multiplied
  } plan_t;

  function automatic logic [2:0] f_addr_w(input logic [7:0] b);
    return {1'b0, b[3:2]} + 3'd1;
  endfunction

  function automatic logic [2:0] f_data_w(input logic [7:0] b);
    return {1'b0, b[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
  import dbg_pkg::*;
#(
  parameter int KEY_LEN = 8
) (
  input  logic [7:0] op_byte,
  output plan_t      plan
);
  op_e code;
  assign code = op_e'(op_byte[7:5]);

  always_comb begin
    plan        = '0;
    plan.a_w    = f_addr_w(op_byte);
    plan.b_w    = f_data_w(op_byte);
    plan.b_fix  = 4'd1;
    unique case (code)
      OP_LDD: begin plan.a_en = 1'b1; plan.b_host = 1'b0; end
      OP_STD: begin plan.a_en = 1'b1; plan.b_host = 1'b1; end
      OP_LDI: begin plan.b_mult = 1'b1; plan.b_host = 1'b0; end
      OP_STI: begin plan.b_mult = 1'b1; plan.b_host = 1'b1; end
      OP_LCR: begin plan.b_w = 3'd1; plan.b_host = 1'b0; end
      OP_SCR: begin plan.b_w = 3'd1; plan.b_host = 1'b1; end
      OP_RPT: begin plan.b_host = 1'b1; end
      OP_KEY: begin plan.b_w = 3'd1; plan.b_host = 1'b1; plan.b_fix = 4'(KEY_LEN); end
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_item_asm.sv
module dbg_item_asm #(
  parameter int MAXB = 4,
  localparam int DW  = 8 * MAXB,
  localparam int IW  = $clog2(MAXB) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [7:0]    din,
  input  logic [2:0]    width,
  output logic          last,
  output logic [DW-1:0] value
);
  logic [IW-1:0] idx;
  logic [DW-1:0] acc;

  assign last  = take && ({{(8-IW){1'b0}}, idx} == {5'd0, width} - 8'd1);
  assign value = acc | (DW'(din) << (8 * idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else if (clr || last) begin
      idx <= '0;
      acc <= '0;
    end else if (take) begin
      acc <= value;
      idx <= idx + 1'b1;
    end
  end

  assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ({{(8-IW){1'b0}}, idx} < {5'd0, width}));
endmodule

// File: rtl/dbg_insn_parser.sv
module dbg_insn_parser
  import dbg_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int ITEM_BYTES = 4,
  parameter int KEY_LEN    = 8,
  localparam int DW        = 8 * ITEM_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          brk_valid,
  output logic          op_valid,
  output logic [2:0]    op_code,
  output logic [2:0]    op_aw,
  output logic [2:0]    op_dw,
  output logic          item_valid,
  output logic [DW-1:0] item_data,
  output logic          item_host,
  output logic [2:0]    item_width,
  output logic          cmd_done,
  output logic [2:0]    cmd_code
);
  typedef enum logic [1:0] {S_OP, S_A, S_B} st_e;

  st_e              st;
  logic [2:0]       op_q, cur_w, b_w_q;
  logic             cur_host, b_host_q;
  logic [CNT_W:0]   remain;
  logic [CNT_W-1:0] rep_q;
  plan_t            plan;
  logic             asm_last;
  logic [DW-1:0]    asm_value;

  // Named internal events
  logic op_take, take, item_end, insn_end;
  assign op_take  = byte_valid && !brk_valid && (st == S_OP);
  assign take     = byte_valid && !brk_valid && (st != S_OP);
  assign item_end = take && asm_last;
  assign insn_end = item_end && (st == S_B) && (remain == (CNT_W+1)'(1));

  dbg_op_decode #(.KEY_LEN(KEY_LEN)) u_dec (.op_byte(byte_data), .plan(plan));

  dbg_item_asm #(.MAXB(ITEM_BYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(brk_valid), .take(take), .din(byte_data),
    .width(cur_w), .last(asm_last), .value(asm_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OP; op_q <= '0; cur_w <= 3'd1; b_w_q <= 3'd1;
      cur_host <= 1'b0; b_host_q <= 1'b0; remain <= '0; rep_q <= '0;
    end else if (brk_valid) begin
      st <= S_OP; rep_q <= '0;
    end else if (op_take) begin
      op_q     <= byte_data[7:5];
      b_w_q    <= plan.b_w;
      b_host_q <= plan.b_host;
      remain   <= plan.b_mult ? ({1'b0, rep_q} + 1'b1) : (CNT_W+1)'(plan.b_fix);
      if (plan.b_mult) rep_q <= '0;
      st       <= plan.a_en ? S_A : S_B;
      cur_w    <= plan.a_en ? plan.a_w : plan.b_w;
      cur_host <= plan.a_en ? 1'b1 : plan.b_host;
    end else if (item_end) begin
      if (st == S_A) begin
        st <= S_B; cur_w <= b_w_q; cur_host <= b_host_q;
      end else if (insn_end) begin
        st <= S_OP;
        if (op_q == OP_RPT) rep_q <= asm_value[CNT_W-1:0];
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0; op_code <= '0; op_aw <= '0; op_dw <= '0;
      item_valid <= 1'b0; item_data <= '0; item_host <= 1'b0; item_width <= '0;
      cmd_done <= 1'b0; cmd_code <= '0;
    end else begin
      op_valid   <= op_take;
      item_valid <= item_end;
      cmd_done   <= insn_end;
      if (op_take) begin
        op_code <= byte_data[7:5];
        op_aw   <= f_addr_w(byte_data);
        op_dw   <= f_data_w(byte_data);
      end
      if (item_end) begin
        item_data  <= asm_value;
        item_host  <= cur_host;
        item_width <= cur_w;
      end
      if (insn_end) cmd_code <= op_q;
    end
  end

  assert_brk_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brk_valid) |-> (!op_valid && !item_valid && !cmd_done));
  assert_brk_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_valid |=> (rep_q == '0 && st == S_OP));
  assert_op_not_item_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && item_valid));
  assert_done_with_item_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> item_valid);
  assert_item_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid |-> (item_width >= 3'd1 && item_width <= 3'(ITEM_BYTES)
                    && (item_data >> (8 * item_width)) == '0));
  assert_rep_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_take && plan.b_mult) |=> (rep_q == '0));
endmodule

// File: tb/dbg_insn_parser_tb.sv
module dbg_insn_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        brk_valid = 1'b0;
  logic        op_valid, item_valid, item_host, cmd_done;
  logic [2:0]  op_code, op_aw, op_dw, item_width, cmd_code;
  logic [31:0] item_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Event word: {kind[1:0], code[2:0], host, width[2:0], data[31:0]}
  logic [40:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dbg_insn_parser u_dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .brk_valid(brk_valid), .op_valid(op_valid), .op_code(op_code), .op_aw(op_aw),
    .op_dw(op_dw), .item_valid(item_valid), .item_data(item_data),
    .item_host(item_host), .item_width(item_width), .cmd_done(cmd_done),
    .cmd_code(cmd_code)
  );

  task automatic check_ev(input logic [40:0] got);
    logic [40:0] e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event: actual %h expected none", "R8/R10", got);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e !== got) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, got, e);
      end
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (op_valid)   check_ev({2'd0, op_code, 1'b0, op_aw, 29'd0, op_dw});
      if (item_valid) check_ev({2'd1, 3'd0, item_host, item_width, item_data});
      if (cmd_done)   check_ev({2'd2, cmd_code, 1'b0, 3'd0, 32'd0});
    end
  end

  task automatic send(input logic [7:0] b);
    byte_data = b; byte_valid = 1'b1;
    @(posedge clk); #1;
    byte_valid = 1'b0;
  endtask

  task automatic brk();
    brk_valid = 1'b1;
    @(posedge clk); #1;
    brk_valid = 1'b0;
  endtask

  task automatic opc(input logic [7:0] b, input string t);
    logic [2:0] aw, dw;
    aw = 3'((b >> 2) & 8'h3) + 3'd1;
    dw = 3'(b & 8'h3) + 3'd1;
    exp_q.push_back({2'd0, b[7:5], 1'b0, aw, 29'd0, dw});
    tag_q.push_back(t);
    send(b);
  endtask

  task automatic item(input bit host, input int w, input logic [31:0] v,
                      input bit last, input logic [2:0] code, input string t);
    exp_q.push_back({2'd1, 3'd0, host, 3'(w), v});
    tag_q.push_back(t);
    if (last) begin
      exp_q.push_back({2'd2, code, 1'b0, 3'd0, 32'd0});
      tag_q.push_back({t, " R9"});
    end
    for (int i = 0; i < w; i++) send(v[8*i +: 8]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    checks++;  // reset state, R10
    if ({op_valid, item_valid, cmd_done} !== 3'b000) begin
      errors++;
      $display("FAIL R10 reset: actual %b expected 000", {op_valid, item_valid, cmd_done});
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 R2 R5: direct load, 2-byte address, 1-byte data
    opc(8'h04, "R1 direct load");
    item(1'b1, 2, 32'h0000_1234, 1'b0, 3'd0, "R2 R5 load addr");
    item(1'b0, 1, 32'h0000_00AB, 1'b1, 3'd0, "R2 load data");
    // R2 R5: direct store, 4-byte address and data
    opc(8'h4F, "R1 direct store");
    item(1'b1, 4, 32'hDEAD_BEEF, 1'b0, 3'd2, "R2 R5 store addr");
    item(1'b1, 4, 32'h0102_0304, 1'b1, 3'd2, "R2 R5 store data");
    // R4: control load/store
    opc(8'h82, "R1 control load");
    item(1'b0, 1, 32'h0000_0080, 1'b1, 3'd4, "R4 control load");
    opc(8'hC5, "R1 control store");
    item(1'b1, 1, 32'h0000_0059, 1'b1, 3'd6, "R4 control store");
    // R4: key, eight single-byte host items
    opc(8'hE3, "R1 key");
    for (int k = 0; k < 8; k++)
      item(1'b1, 1, 32'(8'h10 + k), k == 7, 3'd7, "R4 key byte");
    // R3: indirect load/store without repeat
    opc(8'h22, "R1 indirect load");
    item(1'b0, 3, 32'h00C0_FFEE, 1'b1, 3'd1, "R3 R5 indirect load");
    opc(8'h60, "R1 indirect store");
    item(1'b1, 1, 32'h0000_0007, 1'b1, 3'd3, "R3 indirect store");
    // R6 R7: repeat 2, unrelated control store, then indirect store x3
    opc(8'hA1, "R1 repeat");
    item(1'b1, 2, 32'h0000_0002, 1'b1, 3'd5, "R6 repeat value");
    opc(8'hC3, "R1 control store");
    item(1'b1, 1, 32'h0000_0055, 1'b1, 3'd6, "R7 count kept");
    opc(8'h61, "R1 indirect store");
    item(1'b1, 2, 32'h0000_1111, 1'b0, 3'd3, "R6 R7 rep item 1");
    item(1'b1, 2, 32'h0000_2222, 1'b0, 3'd3, "R6 rep item 2");
    item(1'b1, 2, 32'h0000_3333, 1'b1, 3'd3, "R6 rep item 3");
    opc(8'h20, "R1 indirect load");
    item(1'b0, 1, 32'h0000_0044, 1'b1, 3'd1, "R6 count consumed");
    // R8: break mid-instruction, next byte is an opcode
    opc(8'h00, "R1 direct load");
    item(1'b1, 1, 32'h0000_0033, 1'b0, 3'd0, "R8 addr before break");
    brk();
    opc(8'hC0, "R8 opcode after break");
    item(1'b1, 1, 32'h0000_0066, 1'b1, 3'd6, "R8 control store");
    // R8: break clears a pending repeat count; break beats a byte
    opc(8'hA0, "R1 repeat");
    item(1'b1, 1, 32'h0000_0003, 1'b1, 3'd5, "R6 repeat value");
    byte_data = 8'h5A; byte_valid = 1'b1;
    brk();
    byte_valid = 1'b0;
    opc(8'h20, "R8 opcode after break");
    item(1'b0, 1, 32'h0000_0099, 1'b1, 3'd1, "R8 count cleared");
    repeat (4) @(posedge clk);
    #1;

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending events: actual %0d expected 0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule